// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block takes a received Ethernet frame as a byte stream and stores it in host memory. It finds where to put the frame by walking a list of four-word receive descriptors that are also held in memory. Each descriptor that hardware owns gives one or two data buffers. The engine packs the frame bytes into 32-bit little-endian memory writes and fills each buffer up to its size. After each descriptor is used, it writes back a status word. It then moves to the next descriptor: the ring base, a chained pointer, or the next slot 16 bytes further on.

Software sets up the descriptors. It controls the engine through the receive enable, the DMA start and the ring base address. It watches the 3-bit process state and two sticky flags, one for descriptor unavailable and one for frame complete. A flush flag is set by the engine after every stored frame and is cleared by software. While this flag is clear, a frame that runs out of descriptors is marked as an error.

Top module: `rxdesc_dma`

## Requirements
- R1: A frame is taken only when `rx_en` and `dma_start` are both high while its first byte (`in_sof`) waits. Otherwise every byte up to and including `in_eof` is consumed and discarded, with no memory access and no change of state.
- R2: When a frame is taken and the current descriptor address is zero, the address is first loaded from `ring_base`.
- R3: `proc_state` reads as follows:
  - 0 after reset;
  - 1 while descriptors are fetched for a new frame;
  - 7 while data moves;
  - 5 while the final status is written;
  - 3 once a frame is done or unavailability is cleared;
  - 4 when suspended.
- R4: If word 0 bit 31 (owner) of the first descriptor is clear, the engine does the following:
  - it sets `unavail` and `complete`;
  - `proc_state` becomes 4;
  - the frame is dropped with no memory write, and the descriptor address is kept;
  - a `clr_unavail` pulse clears `unavail` and returns the state to 3.
- R5: Buffer size and byte placement follow these rules:
  - Buffer 1 (address in word 2, size in word 1 bits 10:0) takes the lesser of its size and the bytes left.
  - Bytes go little-endian into 32-bit words at the buffer address plus offset.
  - A word is written when lane 3 is filled, the buffer is full or the frame ends, with a byte enable for each filled lane.
- R6: Buffer 2 (address in word 3, size in word 1 bits 21:11) is used only when bytes are still left after buffer 1 and word 1 bit 24 (chained) is clear.
- R7: The number of bytes stored is the frame length plus four zero bytes in place of the checksum.
- R8: Word 0 of each used descriptor is written back as follows:
  - bit 31 is cleared and bit 5 (frame type) is set;
  - bits 29:16 hold the bytes stored so far in the frame;
  - bit 9 (first segment) is set only in the first descriptor;
  - bit 8 (last segment) is set only in the final descriptor.
- R9: The next descriptor address is chosen in this order: `ring_base` if word 1 bit 25 (end of ring) is set, else word 3 if chained, else the current address plus 16.
- R10: If a follow-on descriptor is owned by software, the frame ends there and the rest of the input is discarded. That descriptor gets last segment, the count so far, and bit 14 (error) unless `flush_o` is already high.
- R11: At frame end the following happen:
  - `complete` is set unless bit 31 of the final descriptor's word 1 is set;
  - `flush_o` is set;
  - the state becomes 3;
  - `cur_desc` moves to the next descriptor.
- R12: `in_ready` is low whenever a memory request is outstanding. A request holds its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | MAC receive enable |
| dma_start | input | 1 | DMA receive start |
| ring_base | input | ADDR_W | Descriptor ring base address |
| flush_clr | input | 1 | Pulse: clear the flush flag |
| clr_unavail | input | 1 | Pulse: clear unavailable flag, resume |
| clr_complete | input | 1 | Pulse: clear complete flag |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_ready | output | 1 | Byte accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Request completed |
| proc_state | output | 3 | Process state code |
| unavail | output | 1 | Descriptor unavailable flag |
| complete | output | 1 | Frame complete flag |
| flush_o | output | 1 | Flush flag |
| cur_desc | output | ADDR_W | Current descriptor address |
| cur_buf | output | ADDR_W | Current buffer address |

## Verification
Every memory write is due in the cycle that its request is acknowledged. The scoreboard compares each write at the falling edge of the acknowledge cycle, while address, data and enables are still held. Flags, state and the descriptor pointer change one edge after the status write-back is acknowledged. They are checked after a fixed wait that covers the longest frame sequence. A dropped or refused frame is checked by seeing no write at all and unchanged outputs after the same wait.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_RD, S_CHK, S_XFER, S_WR, S_BUFEND, S_WB
  } rx_st_t;

  localparam logic [2:0] PS_STOP  = 3'd0;
  localparam logic [2:0] PS_FETCH = 3'd1;
  localparam logic [2:0] PS_WAIT  = 3'd3;
  localparam logic [2:0] PS_SUSP  = 3'd4;
  localparam logic [2:0] PS_CLOSE = 3'd5;
  localparam logic [2:0] PS_XFER  = 3'd7;

  localparam int W0_OWN   = 31;
  localparam int W0_LEN   = 16;
  localparam int W0_ERR   = 14;
  localparam int W0_FIRST = 9;
  localparam int W0_LAST  = 8;
  localparam int W0_TYPE  = 5;
  localparam int W1_NOINT = 31;
  localparam int W1_RING  = 25;
  localparam int W1_CHAIN = 24;
  localparam int W1_SZ2   = 11;
  localparam int W1_SZ1   = 0;
endpackage

// File: rtl/rxdesc_next_sel.sv
module rxdesc_next_sel #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] link,
  input  logic              end_ring,
  input  logic              chained,
  output logic [ADDR_W-1:0] next
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);
  always_comb begin
    if (end_ring)     next = base;
    else if (chained) next = link;
    else              next = cur + STEP;
  end
endmodule

// File: rtl/rxdesc_lane_merge.sv
module rxdesc_lane_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0]         word_in,
  input  logic [LANES-1:0]           be_in,
  input  logic [$clog2(LANES)-1:0]   lane,
  input  logic [7:0]                 byte_in,
  output logic [LANES*8-1:0]         word_out,
  output logic [LANES-1:0]           be_out
);
  localparam int LW = $clog2(LANES);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign word_out[i*8 +: 8] = (lane == LW'(i)) ? byte_in : word_in[i*8 +: 8];
    assign be_out[i]          = (lane == LW'(i)) | be_in[i];
  end
endmodule

// File: rtl/rxdesc_status_word.sv
module rxdesc_status_word
  import rxdesc_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic [LEN_W-1:0] len,
  input  logic             first,
  input  logic             last,
  input  logic             err,
  output logic [31:0]      word
);
  always_comb begin
    word = '0;
    word[W0_LEN +: LEN_W] = len;
    word[W0_ERR]   = err;
    word[W0_FIRST] = first;
    word[W0_LAST]  = last;
    word[W0_TYPE]  = 1'b1;
    word[W0_OWN]   = 1'b0;
  end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
  import rxdesc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14,
  parameter int BSZ_W  = 11,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              dma_start,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              flush_clr,
  input  logic              clr_unavail,
  input  logic              clr_complete,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [2:0]        proc_state,
  output logic              unavail,
  output logic              complete,
  output logic              flush_o,
  output logic [ADDR_W-1:0] cur_desc,
  output logic [ADDR_W-1:0] cur_buf
);
  localparam int PAD_N = 4;
  localparam int PAD_W = $clog2(PAD_N);

  rx_st_t             st;
  logic [31:0]        dw [4];
  logic [1:0]         wcnt;
  logic [BSZ_W-1:0]   buf_size, buf_cnt;
  logic               buf_sel, first_desc, eof_seen, closing, err_q;
  logic [PAD_W-1:0]   pad_cnt;
  logic [LEN_W-1:0]   total;
  logic [31:0]        wdata_q;
  logic [3:0]         be_q;
  logic [ADDR_W-1:0]  wr_addr;

  logic [ADDR_W-1:0]  byte_addr, next_desc;
  logic [31:0]        merged, status_word;
  logic [3:0]         merged_be;
  logic               byte_avail, is_last, buf_full, last_in_buf;
  logic [7:0]         byte_val;

  assign byte_addr   = cur_buf + ADDR_W'(buf_cnt);
  assign byte_avail  = eof_seen | in_valid;
  assign byte_val    = eof_seen ? 8'h00 : in_data;
  assign is_last     = eof_seen && (pad_cnt == PAD_W'(PAD_N - 1));
  assign buf_full    = (buf_cnt == buf_size);
  assign last_in_buf = ((buf_cnt + BSZ_W'(1)) == buf_size);

  rxdesc_lane_merge #(.LANES(4)) u_merge (
    .word_in(wdata_q), .be_in(be_q), .lane(byte_addr[1:0]), .byte_in(byte_val),
    .word_out(merged), .be_out(merged_be)
  );

  rxdesc_next_sel #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_next (
    .cur(cur_desc), .base(ring_base), .link(dw[3][ADDR_W-1:0]),
    .end_ring(dw[1][W1_RING]), .chained(dw[1][W1_CHAIN]), .next(next_desc)
  );

  rxdesc_status_word #(.LEN_W(LEN_W)) u_status (
    .len(total), .first(first_desc), .last(closing), .err(err_q), .word(status_word)
  );

  always_comb begin
    case (st)
      S_IDLE:  in_ready = !(rx_en && dma_start && in_sof);
      S_DRAIN: in_ready = 1'b1;
      S_XFER:  in_ready = !eof_seen && !buf_full;
      default: in_ready = 1'b0;
    endcase
    mem_req   = (st == S_RD) || (st == S_WR) || (st == S_WB);
    mem_we    = (st == S_WR) || (st == S_WB);
    mem_wdata = (st == S_WB) ? status_word : wdata_q;
    mem_be    = (st == S_WR) ? be_q : 4'hf;
    case (st)
      S_RD:    mem_addr = cur_desc + ADDR_W'({wcnt, 2'b00});
      S_WR:    mem_addr = wr_addr;
      default: mem_addr = cur_desc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; wcnt <= '0; buf_size <= '0; buf_cnt <= '0; buf_sel <= 1'b0;
      first_desc <= 1'b0; eof_seen <= 1'b0; closing <= 1'b0; err_q <= 1'b0;
      pad_cnt <= '0; total <= '0; wdata_q <= '0; be_q <= '0; wr_addr <= '0;
      proc_state <= PS_STOP; unavail <= 1'b0; complete <= 1'b0; flush_o <= 1'b0;
      cur_desc <= '0; cur_buf <= '0;
      for (int i = 0; i < 4; i++) dw[i] <= '0;
    end else begin
      if (clr_unavail) begin
        unavail <= 1'b0;
        if (proc_state == PS_SUSP) proc_state <= PS_WAIT;
      end
      if (clr_complete) complete <= 1'b0;
      if (flush_clr) flush_o <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          if (rx_en && dma_start && in_sof) begin
            if (cur_desc == '0) cur_desc <= ring_base;
            total <= '0; first_desc <= 1'b1; eof_seen <= 1'b0; pad_cnt <= '0;
            closing <= 1'b0; err_q <= 1'b0; wcnt <= '0;
            proc_state <= PS_FETCH; st <= S_RD;
          end else if (!in_eof) st <= S_DRAIN;
        end
        S_DRAIN: if (in_valid && in_eof) st <= S_IDLE;
        S_RD: if (mem_ack) begin
          dw[wcnt] <= mem_rdata;
          wcnt <= wcnt + 2'd1;
          if (wcnt == 2'd3) st <= S_CHK;
        end
        S_CHK: if (!dw[0][W0_OWN]) begin
          if (first_desc) begin
            unavail <= 1'b1; complete <= 1'b1; proc_state <= PS_SUSP; st <= S_DRAIN;
          end else begin
            err_q <= !flush_o; closing <= 1'b1; proc_state <= PS_CLOSE; st <= S_WB;
          end
        end else begin
          cur_buf <= dw[2][ADDR_W-1:0]; buf_size <= dw[1][W1_SZ1 +: BSZ_W];
          buf_cnt <= '0; buf_sel <= 1'b0; proc_state <= PS_XFER; st <= S_XFER;
        end
        S_XFER: if (buf_full) st <= S_BUFEND;
        else if (byte_avail) begin
          wdata_q <= merged; be_q <= merged_be;
          wr_addr <= {byte_addr[ADDR_W-1:2], 2'b00};
          buf_cnt <= buf_cnt + BSZ_W'(1);
          total   <= total + LEN_W'(1);
          if (eof_seen) pad_cnt <= pad_cnt + PAD_W'(1);
          else if (in_eof) eof_seen <= 1'b1;
          if (byte_addr[1:0] == 2'd3 || last_in_buf || is_last) begin
            closing <= is_last; st <= S_WR;
          end
        end
        S_WR: if (mem_ack) begin
          wdata_q <= '0; be_q <= '0;
          if (closing) begin proc_state <= PS_CLOSE; st <= S_WB; end
          else if (buf_full) st <= S_BUFEND;
          else st <= S_XFER;
        end
        S_BUFEND: if (!buf_sel && !dw[1][W1_CHAIN]) begin
          buf_sel <= 1'b1; cur_buf <= dw[3][ADDR_W-1:0];
          buf_size <= dw[1][W1_SZ2 +: BSZ_W]; buf_cnt <= '0; st <= S_XFER;
        end else st <= S_WB;
        S_WB: if (mem_ack) begin
          first_desc <= 1'b0;
          cur_desc   <= next_desc;
          if (closing) begin
            if (!dw[1][W1_NOINT]) complete <= 1'b1;
            flush_o <= 1'b1; proc_state <= PS_WAIT;
            st <= eof_seen ? S_IDLE : S_DRAIN;
          end else begin
            wcnt <= '0; st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              mem_ack,
  input logic [2:0]        proc_state,
  input logic              unavail,
  input logic              complete,
  input logic              flush_o,
  input logic              clr_unavail,
  input logic              flush_clr
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_no_take_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !in_ready);
  assert_write_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_be != 4'b0000);
  assert_state_code_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> proc_state inside {3'd1, 3'd5, 3'd7});
  assert_suspend_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(unavail) |-> complete && proc_state == 3'd4);
  assert_unavail_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(unavail) |-> $past(clr_unavail));
  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_o) |-> $past(flush_clr));
endmodule

bind rxdesc_dma rxdesc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_ack(mem_ack), .proc_state(proc_state),
  .unavail(unavail), .complete(complete), .flush_o(flush_o),
  .clr_unavail(clr_unavail), .flush_clr(flush_clr)
);

// File: tb/rxdesc_dma_test.sv
module rxdesc_dma_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, rx_en, dma_start, flush_clr, clr_unavail, clr_complete;
  logic [31:0] ring_base;
  logic in_valid, in_sof, in_eof, in_ready;
  logic [7:0] in_data;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [2:0] proc_state;
  logic unavail, complete, flush_o;
  logic [31:0] cur_desc, cur_buf;

  rxdesc_dma uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .dma_start(dma_start), .ring_base(ring_base),
    .flush_clr(flush_clr), .clr_unavail(clr_unavail), .clr_complete(clr_complete),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .proc_state(proc_state), .unavail(unavail), .complete(complete), .flush_o(flush_o),
    .cur_desc(cur_desc), .cur_buf(cur_buf)
  );

  logic [31:0] mem [256];
  logic poke_en;
  logic [31:0] poke_addr, poke_data;
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (poke_en) mem[poke_addr[9:2]] <= poke_data;
    else if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we)
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[9:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end
  end

  typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] b; string tag; } wr_t;
  wr_t exp_q[$];
  int total = 0, bad = 0, r12_viol = 0;
  bit [7:0] seen;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b, input string tag);
    wr_t w;
    w.a = a; w.d = d; w.b = b; w.tag = tag;
    exp_q.push_back(w);
  endtask

  always @(negedge clk) begin
    seen[proc_state] = 1'b1;
    if (mem_req && in_ready) r12_viol++;
    if (!rst && mem_req && mem_we && mem_ack) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected write", {mem_addr, mem_wdata}, 64'h0);
      else begin
        wr_t w;
        w = exp_q.pop_front();
        check(mem_addr == w.a && mem_wdata == w.d && mem_be == w.b, w.tag,
              {mem_addr, mem_wdata[27:0], mem_be}, {w.a, w.d[27:0], w.b});
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) clr_complete = 1'b1;
    if (which == 1) flush_clr = 1'b1;
    if (which == 2) clr_unavail = 1'b1;
    @(negedge clk);
    clr_complete = 1'b0; flush_clr = 1'b0; clr_unavail = 1'b0;
  endtask

  task automatic send(input logic [7:0] b[$]);
    for (int i = 0; i < b.size(); i++) begin
      in_valid = 1'b1; in_data = b[i];
      in_sof = (i == 0); in_eof = (i == b.size() - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_en = 1'b0; dma_start = 1'b0; ring_base = 32'h100;
    flush_clr = 1'b0; clr_unavail = 1'b0; clr_complete = 1'b0;
    in_valid = 1'b0; in_data = 8'h00; in_sof = 1'b0; in_eof = 1'b0;
    poke_en = 1'b0; poke_addr = '0; poke_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(proc_state == 3'd0, "R3 reset state", 64'(proc_state), 64'd0);
    check(!unavail && !complete && !flush_o, "R3 reset flags", {unavail, complete, flush_o}, 64'd0);
    check(cur_desc == 32'h0, "R3 reset desc", 64'(cur_desc), 64'd0);

    // R1: refused while receive disabled
    dma_start = 1'b1;
    send('{8'h55, 8'h66, 8'h77});
    repeat (30) @(negedge clk);
    check(proc_state == 3'd0 && cur_desc == 32'h0, "R1 refused frame", {proc_state, cur_desc}, 64'h0);

    // descriptors
    poke(32'h100, 32'h8000_0000); poke(32'h104, 32'h0000_0008);
    poke(32'h108, 32'h200);       poke(32'h10C, 32'h240);
    poke(32'h110, 32'h8000_0000); poke(32'h114, 32'h8000_2803);
    poke(32'h118, 32'h300);       poke(32'h11C, 32'h320);
    poke(32'h120, 32'h8000_0000); poke(32'h124, 32'h0100_3804);
    poke(32'h128, 32'h340);       poke(32'h12C, 32'h180);
    poke(32'h180, 32'h8000_0000); poke(32'h184, 32'h0200_0010);
    poke(32'h188, 32'h360);       poke(32'h18C, 32'h0);

    // R2 R5 R7 R8: single buffer, base load
    rx_en = 1'b1; seen = '0;
    expect_wr(32'h200, 32'h0000_2211, 4'hf, "R5 R7 word 0");
    expect_wr(32'h204, 32'h0000_0000, 4'h3, "R7 pad tail");
    expect_wr(32'h100, 32'h0006_0320, 4'hf, "R8 single desc status");
    send('{8'h11, 8'h22});
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R7 all writes seen", 64'(exp_q.size()), 64'd0);
    check(seen[1] && seen[7] && seen[5], "R3 state sequence", 64'(seen), 64'hA2);
    check(proc_state == 3'd3, "R3 waiting", 64'(proc_state), 64'd3);
    check(complete && flush_o, "R11 flags set", {complete, flush_o}, 64'h3);
    check(cur_desc == 32'h110, "R9 R2 next sequential", 64'(cur_desc), 64'h110);

    // R6: two buffers, completion irq disabled
    pulse(0); pulse(1);
    expect_wr(32'h300, 32'h00CC_BBAA, 4'h7, "R5 buffer1 partial");
    expect_wr(32'h320, 32'h0000_00DD, 4'hf, "R6 buffer2 word");
    expect_wr(32'h324, 32'h0000_0000, 4'h1, "R6 buffer2 tail");
    expect_wr(32'h110, 32'h0008_0320, 4'hf, "R8 two-buffer status");
    send('{8'hAA, 8'hBB, 8'hCC, 8'hDD});
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R6 all writes seen", 64'(exp_q.size()), 64'd0);
    check(!complete && flush_o, "R11 no-irq bit", {complete, flush_o}, 64'h1);
    check(cur_desc == 32'h120, "R9 sequential", 64'(cur_desc), 64'h120);

    // R9: chained then end of ring, two descriptors
    expect_wr(32'h340, 32'h0003_0201, 4'hf, "R6 chained buffer1 only");
    expect_wr(32'h120, 32'h0004_0220, 4'hf, "R8 first segment");
    expect_wr(32'h360, 32'h0000_0000, 4'h7, "R7 pad in next desc");
    expect_wr(32'h180, 32'h0007_0120, 4'hf, "R8 last segment");
    send('{8'h01, 8'h02, 8'h03});
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R9 all writes seen", 64'(exp_q.size()), 64'd0);
    check(complete, "R11 complete", 64'(complete), 64'd1);
    check(cur_desc == 32'h100, "R9 ring wrap", 64'(cur_desc), 64'h100);

    // R10: follow-on owned by software, flush clear
    poke(32'h100, 32'h8000_0000); poke(32'h104, 32'h0100_0004);
    poke(32'h108, 32'h380);       poke(32'h10C, 32'h1C0);
    poke(32'h1C0, 32'h0);         poke(32'h1C4, 32'h0);
    poke(32'h1C8, 32'h0);         poke(32'h1CC, 32'h0);
    pulse(0); pulse(1);
    expect_wr(32'h380, 32'h0403_0201, 4'hf, "R10 data before stop");
    expect_wr(32'h100, 32'h0004_0220, 4'hf, "R10 first desc status");
    expect_wr(32'h1C0, 32'h0004_4120, 4'hf, "R10 error and last");
    send('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05});
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R10 all writes seen", 64'(exp_q.size()), 64'd0);
    check(cur_desc == 32'h1D0 && complete, "R10 next desc", {complete, cur_desc}, {1'b1, 32'h1D0});

    // R4: first descriptor owned by software
    poke(32'h1D0, 32'h0); poke(32'h1D4, 32'h0);
    pulse(0);
    send('{8'h9A, 8'hBC});
    repeat (40) @(negedge clk);
    check(unavail && complete && proc_state == 3'd4, "R4 suspend", {unavail, complete, proc_state}, 64'h1C);
    check(cur_desc == 32'h1D0, "R4 desc kept", 64'(cur_desc), 64'h1D0);
    pulse(2);
    @(negedge clk);
    check(!unavail && proc_state == 3'd3, "R4 resume", {unavail, proc_state}, 64'h3);

    check(r12_viol == 0, "R12 no byte during request", 64'(r12_viol), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule